// File: doc/BRIEF.md
# Temperature Limit Interrupt Generator

This block watches the die-temperature samples produced by a conversion engine and raises an interrupt when the temperature goes outside a programmed window. Each sample is a 9-bit two's-complement word. The upper eight bits hold signed whole degrees, and the lowest bit adds half a degree. The block looks at a sample only when the conversion-complete strobe arrives with it. It compares the whole-degree part against a signed high limit and a signed low (hysteresis) limit, and updates a status bit.

A 2-bit mode field selects one of three interrupt behaviours:

- **Repetitive:** the status is set on every conversion found above the high limit.
- **One-time:** the status is set once when the temperature rises past the high limit, then once when it falls below the low limit, and so on.
- **Comparator:** the status simply tracks whether the last sample was above the high limit.

In the repetitive and one-time modes the status holds until software pulses the clear strobe. The interrupt output is the status bit gated by a global enable.

Top module: `thermal_irq_gen`

## Requirements
- R1: Only the whole-degree part (bits 8:1 of the temperature word) takes part in a limit comparison; the half-degree bit 0 has no effect on the result.
- R2: Temperature and both limits are compared as signed 8-bit values; a sample is "hot" when strictly greater than the high limit and "cold" when strictly less than the low limit.
- R3: Mode field decoding: 2'b00 and 2'b11 select repetitive, 2'b01 selects one-time, and 2'b10 selects comparator.
- R4: In repetitive mode, every conversion strobe with a hot sample sets the status bit, including repeated hot samples after a clear.
- R5: In repetitive and one-time modes, the status bit stays set until a clear strobe. A clear in the same cycle as a setting conversion leaves the status set.
- R6: In one-time mode, a hot sample sets the status only while waiting for a high crossing, and then the block waits for a low crossing. A cold sample sets the status only while waiting for a low crossing, and then the block waits for a high crossing again.
- R7: The one-time arming state starts as "waiting for high crossing" after reset. It returns to that state in any cycle where the mode field does not select one-time.
- R8: In comparator mode, the status bit takes the hot result at each conversion strobe. It holds between strobes, and the clear strobe has no effect on it.
- R9: A high limit of +127 (8'h7F) disables the hot result, so no sample ever sets the status through the high limit.
- R10: The status bit changes only in the clock edge that samples a conversion strobe or a clear strobe. It is visible in the following cycle.
- R11: The interrupt output equals the status bit ANDed with the interrupt enable input, with no added delay.
- R12: After reset, the status bit and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_word | input | 9 | Sampled temperature, two's complement, LSB = 0.5 degree |
| conv_done | input | 1 | One-cycle strobe marking a new temperature sample |
| high_lim | input | 8 | Signed high limit in whole degrees |
| low_lim | input | 8 | Signed low (hysteresis) limit in whole degrees |
| mode_sel | input | 2 | Interrupt behaviour select |
| stat_clr | input | 1 | Status read/clear strobe |
| irq_en | input | 1 | Global interrupt enable |
| stat_bit | output | 1 | Temperature status bit |
| irq | output | 1 | Interrupt request, active high |

## Verification
The case hardest to reach from the ports is the one-time arming state, because nothing reports it directly. The bench infers it from whether a later crossing sets the status. It walks the temperature above the high limit and clears the status. It then shows that further hot samples stay silent while only a drop below the low limit fires. To prove the arming reset, it briefly switches the mode away from one-time and back while the block is waiting for a low crossing, and shows that a hot sample fires again. Signed limits are driven with negative values and negative half-degree samples, which shows that the half bit is dropped rather than rounded.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

  parameter int TEMP_W = 9;
  parameter int FRAC_W = 1;
  localparam int WHOLE_W = TEMP_W - FRAC_W;

  typedef logic signed [WHOLE_W-1:0] deg_t;

  localparam deg_t DISABLE_LIM = deg_t'({1'b0, {(WHOLE_W-1){1'b1}}});

  typedef enum logic [1:0] {
    TM_REPEAT = 2'd0,
    TM_ONCE   = 2'd1,
    TM_FOLLOW = 2'd2
  } tmode_e;

  // Drop the fractional bits; arithmetic shift keeps the sign (floor).
  function automatic deg_t whole_deg(input logic [TEMP_W-1:0] w);
    return $signed(w[TEMP_W-1:FRAC_W]);
  endfunction

  // Two codes alias onto repetitive behaviour.
  function automatic tmode_e decode_mode(input logic [1:0] f);
    case (f)
      2'b01:   return TM_ONCE;
      2'b10:   return TM_FOLLOW;
      default: return TM_REPEAT;
    endcase
  endfunction

  function automatic logic over_high(input deg_t t, input deg_t h);
    return (h != DISABLE_LIM) && (t > h);
  endfunction

  function automatic logic under_low(input deg_t t, input deg_t l);
    return t < l;
  endfunction

endpackage

// File: rtl/tirq_compare.sv
module tirq_compare
  import tirq_pkg::*;
(
  input  logic [TEMP_W-1:0]  temp_word,
  input  logic [WHOLE_W-1:0] high_lim,
  input  logic [WHOLE_W-1:0] low_lim,
  output logic               hot,
  output logic               cold
);
  deg_t t_deg;
  deg_t h_deg;
  deg_t l_deg;

  always_comb begin
    t_deg = whole_deg(temp_word);
    h_deg = deg_t'(high_lim);
    l_deg = deg_t'(low_lim);
    hot   = over_high(t_deg, h_deg);
    cold  = under_low(t_deg, l_deg);
  end
endmodule

// File: rtl/tirq_arm.sv
module tirq_arm
  import tirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic once_mode,
  input  logic hot,
  input  logic cold,
  output logic fire_once,
  output logic wait_low
);
  always_comb begin
    fire_once = once_mode && conv_done && (wait_low ? cold : hot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_low <= 1'b0;
    end else if (!once_mode) begin
      wait_low <= 1'b0;
    end else if (fire_once) begin
      wait_low <= !wait_low;
    end
  end
endmodule

// File: rtl/tirq_status.sv
module tirq_status
  import tirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  tmode_e mode,
  input  logic   conv_done,
  input  logic   hot,
  input  logic   fire_once,
  input  logic   stat_clr,
  output logic   set_evt,
  output logic   stat
);
  always_comb begin
    case (mode)
      TM_REPEAT: set_evt = conv_done && hot;
      TM_ONCE:   set_evt = fire_once;
      default:   set_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 1'b0;
    end else if (mode == TM_FOLLOW) begin
      if (conv_done) stat <= hot;
    end else if (set_evt) begin
      stat <= 1'b1;
    end else if (stat_clr) begin
      stat <= 1'b0;
    end
  end
endmodule

// File: rtl/thermal_irq_gen.sv
module thermal_irq_gen
  import tirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TEMP_W-1:0]  temp_word,
  input  logic               conv_done,
  input  logic [WHOLE_W-1:0] high_lim,
  input  logic [WHOLE_W-1:0] low_lim,
  input  logic [1:0]         mode_sel,
  input  logic               stat_clr,
  input  logic               irq_en,
  output logic               stat_bit,
  output logic               irq
);
  tmode_e mode;
  logic   hot;
  logic   cold;
  logic   fire_once;
  logic   wait_low;
  logic   set_evt;

  always_comb mode = decode_mode(mode_sel);

  tirq_compare u_cmp (
    .temp_word (temp_word),
    .high_lim  (high_lim),
    .low_lim   (low_lim),
    .hot       (hot),
    .cold      (cold)
  );

  tirq_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .once_mode (mode == TM_ONCE),
    .hot       (hot),
    .cold      (cold),
    .fire_once (fire_once),
    .wait_low  (wait_low)
  );

  tirq_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .conv_done (conv_done),
    .hot       (hot),
    .fire_once (fire_once),
    .stat_clr  (stat_clr),
    .set_evt   (set_evt),
    .stat      (stat_bit)
  );

  assign irq = stat_bit & irq_en;
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done,
  input logic [7:0] high_lim,
  input logic [1:0] mode_sel,
  input logic       stat_clr,
  input logic       irq_en,
  input logic       stat_bit,
  input logic       irq,
  input logic       wait_low,
  input logic       set_evt
);
  assert_rise_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_bit) |-> $past(conv_done));

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b10 && stat_bit && !stat_clr && !conv_done) |=> stat_bit);

  assert_follow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !conv_done) |=> $stable(stat_bit));

  assert_limit_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && high_lim == 8'h7F && mode_sel != 2'b01 && !stat_bit) |=> !stat_bit);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && mode_sel != 2'b10) |=> stat_bit);

  assert_arm_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_low) |-> stat_bit);

  assert_arm_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b01) |=> !wait_low);

  assert_gate_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_gate_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && stat_bit) |-> irq);
endmodule

bind thermal_irq_gen tirq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_done (conv_done),
  .high_lim  (high_lim),
  .mode_sel  (mode_sel),
  .stat_clr  (stat_clr),
  .irq_en    (irq_en),
  .stat_bit  (stat_bit),
  .irq       (irq),
  .wait_low  (wait_low),
  .set_evt   (set_evt)
);

// File: tb/sim_thermal_irq_gen.sv
`timescale 1ns/1ps
module sim_thermal_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] temp_word = '0;
  logic       conv_done = 1'b0;
  logic [7:0] high_lim = '0;
  logic [7:0] low_lim = '0;
  logic [1:0] mode_sel = 2'b00;
  logic       stat_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       stat_bit;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  thermal_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .temp_word(temp_word), .conv_done(conv_done),
    .high_lim(high_lim), .low_lim(low_lim), .mode_sel(mode_sel),
    .stat_clr(stat_clr), .irq_en(irq_en), .stat_bit(stat_bit), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Sample given in half-degree units; status is visible after the edge.
  task automatic convert(input int halves);
    @(negedge clk);
    temp_word = 9'(halves);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic clear_stat();
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input int hi, input int lo);
    @(negedge clk);
    mode_sel = m;
    high_lim = 8'(hi);
    low_lim  = 8'(lo);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 status after reset", stat_bit, 1'b0);
    check("R12 irq after reset", irq, 1'b0);
  endtask

  task automatic t_repeat();
    irq_en = 1'b1;
    setup(2'b00, 50, 40);
    convert(100);  check("R2 equal to high limit is not hot", stat_bit, 1'b0);
    convert(102);  check("R4 hot sets status", stat_bit, 1'b1);
    check("R11 irq follows status", irq, 1'b1);
    clear_stat();  check("R5 clear drops status", stat_bit, 1'b0);
    convert(102);  check("R4 repeated hot sets again", stat_bit, 1'b1);
    convert(60);   check("R5 status sticky after cool sample", stat_bit, 1'b1);
    clear_stat();
    setup(2'b11, 50, 40);
    convert(120);  check("R3 code 11 acts repetitive", stat_bit, 1'b1);
  endtask

  task automatic t_half_bit();
    setup(2'b00, 50, 40);
    convert(101);  check("R1 50.5 not above 50", stat_bit, 1'b0);
    setup(2'b00, -10, -20);
    convert(-19);  check("R1 -9.5 floors to -10", stat_bit, 1'b0);
    convert(-18);  check("R2 -9 above -10 signed", stat_bit, 1'b1);
  endtask

  task automatic t_once();
    setup(2'b01, 50, 40);
    convert(110);  check("R6 upward crossing fires", stat_bit, 1'b1);
    clear_stat();
    convert(120);  check("R6 second hot sample silent", stat_bit, 1'b0);
    convert(90);   check("R6 inside window silent", stat_bit, 1'b0);
    convert(78);   check("R6 downward crossing fires", stat_bit, 1'b1);
    clear_stat();
    convert(70);   check("R6 second cold sample silent", stat_bit, 1'b0);
    convert(102);  check("R6 rearmed for high", stat_bit, 1'b1);
    clear_stat();
    // now waiting for low; leave one-time mode briefly
    @(negedge clk); mode_sel = 2'b00;
    @(negedge clk); mode_sel = 2'b01;
    convert(102);  check("R7 mode change rearms for high", stat_bit, 1'b1);
  endtask

  task automatic t_follow();
    setup(2'b10, 50, 40);
    convert(110);  check("R8 comparator hot", stat_bit, 1'b1);
    clear_stat();  check("R8 clear ignored", stat_bit, 1'b1);
    @(negedge clk); temp_word = 9'(20);
    @(negedge clk); check("R10 no change without strobe", stat_bit, 1'b1);
    convert(100);  check("R8 comparator follows cool", stat_bit, 1'b0);
  endtask

  task automatic t_disable();
    setup(2'b00, 127, 40);
    convert(255);  check("R9 limit 127 disables", stat_bit, 1'b0);
    setup(2'b10, 127, 40);
    convert(254);  check("R9 disabled in comparator", stat_bit, 1'b0);
  endtask

  task automatic t_gate_and_race();
    setup(2'b00, 50, 40);
    irq_en = 1'b0;
    @(negedge clk);
    temp_word = 9'(120); conv_done = 1'b1; stat_clr = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; stat_clr = 1'b0;
    check("R5 set beats simultaneous clear", stat_bit, 1'b1);
    check("R11 irq masked by enable", irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R11 irq on enable without delay", irq, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_repeat();
    t_half_bit();
    t_once();
    t_follow();
    t_disable();
    t_gate_and_race();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule